// File: doc/BRIEF.md
# Receive Holding Buffer with Error Status and Address Wake-up

This block sits between a serial receive engine and a CPU register interface. It stores up to three received characters. Each character is kept with three status bits: parity error, framing error and break. The block tells the CPU whether data is waiting and whether the buffer is full. A data-read strobe removes the oldest character. Error status can be shown per character, or collected across characters until the CPU clears it.

The receive engine reports two events: a valid start bit and a completed character. When the buffer is full, a completed character waits in a single hold stage. The next start bit drops that held character and raises a sticky overrun flag. An optional flow-control output tells the remote sender to pause when a start bit arrives with no room left. The CPU can also issue a receiver reset. This empties the buffer logically and returns both pointers to the first slot, but it leaves the stored bytes in place.

In multidrop wake-up mode, the bit in the parity position is treated as an address/data marker. While the receiver is disabled, this marker decides whether a character is kept.

Top module: `rx_hold_buffer`

## Requirements
- R1: The buffer holds three entries. `ready` is 1 while at least one entry is stored, and `full` is 1 while all three are stored. `rdData` always shows the byte in the slot at the read position. A `dataRd` pulse pops one entry at the clock edge, and a `dataRd` on an empty buffer has no effect. After reset the buffer is empty, every slot is zero and `sendReq` is 1.
- R2: With `blockErrMode`=0, `parityErr`, `frameErr` and `breakSeen` show the three status bits stored with the slot at the read position.
- R3: With `blockErrMode`=1, each status output is the OR of two things: the status of every entry popped since the last `errReset`, and the status of the head entry while `ready` is 1. An `errReset` clears the collected part at the next edge.
- R4: A character that completes while the buffer is full, with no pop in that cycle, is kept in a hold stage. The held character enters the buffer in the same edge that a pop frees a slot, so `full` stays 1.
- R5: A `startBit` while a character is held, with no pop in that cycle, drops the held character and leaves the buffer unchanged. It also sets `overrun` at that edge. `overrun` stays 1 until an `errReset`, and a set in the same cycle wins over the clear.
- R6: With `autoFlow`=1, a `startBit` while `full` is 1 and no pop occurs drives `sendReq` to 0 at the next edge. Any pop drives `sendReq` back to 1 at its edge. With `autoFlow`=0, `sendReq` returns to 1 at the next edge.
- R7: A `rxReset` pulse does all of the following at the next edge: it empties the buffer (`ready`=0, `full`=0), drops the held character, moves both pointers to slot 0 and clears slot 0's status bits. The stored bytes are not erased, so `rdData` then shows slot 0's old byte. Any push or pop requested in that cycle is ignored.
- R8: With `rxEnable`=0 and `wakeMode`=0, completed characters are discarded.
- R9: With `wakeMode`=1 and `rxEnable`=0, a character is stored only if its marker bit (`charParity`) is 1. The marker is stored in the parity status slot.
- R10: With `wakeMode`=1 and `rxEnable`=1, every completed character is stored, whatever its marker bit.
- R11: A pop and a push in the same cycle leave the entry count unchanged, and no entry is lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| rxEnable | input | 1 | Receiver enabled |
| wakeMode | input | 1 | Multidrop address wake-up mode |
| blockErrMode | input | 1 | 1 = accumulated error view, 0 = per-character view |
| autoFlow | input | 1 | Enable automatic flow-control negation |
| startBit | input | 1 | One-cycle pulse: valid start bit detected |
| charDone | input | 1 | One-cycle pulse: character assembled |
| charData | input | DATA_W | Assembled character data |
| charParity | input | 1 | Parity error, or address marker in wake-up mode |
| charFrame | input | 1 | Framing error of the character |
| charBreak | input | 1 | Break detected for the character |
| dataRd | input | 1 | CPU data read, pops the head entry |
| errReset | input | 1 | CPU reset-error command |
| rxReset | input | 1 | CPU receiver reset command |
| rdData | output | DATA_W | Byte at the read position |
| ready | output | 1 | At least one entry stored |
| full | output | 1 | All entries stored |
| parityErr | output | 1 | Reported parity / marker status |
| frameErr | output | 1 | Reported framing status |
| breakSeen | output | 1 | Reported break status |
| overrun | output | 1 | Sticky overrun flag |
| sendReq | output | 1 | Request-to-send, 1 = remote may send |

## Verification
The hardest state to reach is a held character sitting behind a full buffer. From there, the next start bit either overruns it or races a pop in the same cycle. The stimulus gets there by filling the buffer with three characters, completing a fourth without reading, and then issuing a lone start bit. The flow-control output is observed along the way. A later receiver reset, done while the pointers are away from slot 0, shows that the old byte in slot 0 survives while its status is cleared.

// File: rtl/rxhb_pkg.sv
package rxhb_pkg;
  localparam int STAT_W = 3;
  localparam int PAR_B  = 2;
  localparam int FRM_B  = 1;
  localparam int BRK_B  = 0;

  typedef logic [STAT_W-1:0] stat_t;

  typedef struct packed {
    logic pushHold;  // write held character into buffer
    logic pushIn;    // write incoming character into buffer
    logic loadHold;  // capture incoming character into hold stage
    logic popHead;   // head entry leaves
    logic clrHead;   // clear status of slot 0 (receiver reset)
    logic accClr;    // clear accumulated error view
  } strobe_t;
endpackage

// File: rtl/rxhb_ctrl.sv
module rxhb_ctrl
  import rxhb_pkg::*;
#(
  parameter int DEPTH = 3,
  parameter int PTR_W = $clog2(DEPTH),
  parameter int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             rxEnable,
  input  logic             wakeMode,
  input  logic             autoFlow,
  input  logic             startBit,
  input  logic             charDone,
  input  logic             charParity,
  input  logic             dataRd,
  input  logic             errReset,
  input  logic             rxReset,
  output strobe_t          strobe,
  output logic [PTR_W-1:0] wrPtr,
  output logic [PTR_W-1:0] rdPtr,
  output logic             ready,
  output logic             full,
  output logic             overrun,
  output logic             sendReq
);
  localparam logic [CNT_W-1:0] CAP     = CNT_W'(DEPTH);
  localparam logic [PTR_W-1:0] LAST_IX = PTR_W'(DEPTH - 1);

  logic [CNT_W-1:0] count, cntAfterPop;
  logic             holdValid, rtsNeg;
  logic             pop, drain, accept, inPush, inHold, ovSet, push;

  function automatic logic [PTR_W-1:0] nextIx(input logic [PTR_W-1:0] ix);
    return (ix == LAST_IX) ? '0 : ix + 1'b1;
  endfunction

  always_comb begin
    pop         = dataRd && (count != '0) && !rxReset;
    cntAfterPop = count - CNT_W'(pop);
    drain       = holdValid && (cntAfterPop < CAP) && !rxReset;
    accept      = charDone && (rxEnable || (wakeMode && charParity)) && !rxReset;
    inPush      = accept && !holdValid && (cntAfterPop < CAP);
    inHold      = accept && !inPush;
    ovSet       = holdValid && !drain && (startBit || accept) && !rxReset;
    push        = drain || inPush;
  end

  always_comb begin
    strobe          = '0;
    strobe.pushHold = drain;
    strobe.pushIn   = inPush;
    strobe.loadHold = inHold;
    strobe.popHead  = pop;
    strobe.clrHead  = rxReset;
    strobe.accClr   = errReset;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      count     <= '0;
      wrPtr     <= '0;
      rdPtr     <= '0;
      holdValid <= 1'b0;
      rtsNeg    <= 1'b0;
      overrun   <= 1'b0;
    end else begin
      if (ovSet)         overrun <= 1'b1;
      else if (errReset) overrun <= 1'b0;

      if (rxReset) begin
        count     <= '0;
        wrPtr     <= '0;
        rdPtr     <= '0;
        holdValid <= 1'b0;
        rtsNeg    <= 1'b0;
      end else begin
        count <= cntAfterPop + CNT_W'(push);
        if (pop)  rdPtr <= nextIx(rdPtr);
        if (push) wrPtr <= nextIx(wrPtr);

        if (inHold)                     holdValid <= 1'b1;
        else if (drain)                 holdValid <= 1'b0;
        else if (startBit && holdValid) holdValid <= 1'b0;

        if (!autoFlow || pop)                rtsNeg <= 1'b0;
        else if (startBit && count == CAP)   rtsNeg <= 1'b1;
      end
    end
  end

  assign ready   = (count != '0);
  assign full    = (count == CAP);
  assign sendReq = !rtsNeg;
endmodule

// File: rtl/rxhb_data.sv
module rxhb_data
  import rxhb_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 3,
  parameter int PTR_W  = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strobe,
  input  logic [PTR_W-1:0]  wrPtr,
  input  logic [PTR_W-1:0]  rdPtr,
  input  logic              notEmpty,
  input  logic              blockErrMode,
  input  logic [DATA_W-1:0] charData,
  input  logic              charParity,
  input  logic              charFrame,
  input  logic              charBreak,
  output logic [DATA_W-1:0] rdData,
  output stat_t             shownStat
);
  logic [DATA_W-1:0] memData [DEPTH];
  stat_t             memStat [DEPTH];
  logic [DATA_W-1:0] holdData;
  stat_t             holdStat;
  stat_t             accum;
  stat_t             inStat;
  stat_t             headStat;

  always_comb begin
    inStat        = '0;
    inStat[PAR_B] = charParity;
    inStat[FRM_B] = charFrame;
    inStat[BRK_B] = charBreak;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) begin
        memData[i] <= '0;
        memStat[i] <= '0;
      end
      holdData <= '0;
      holdStat <= '0;
      accum    <= '0;
    end else begin
      if (strobe.pushHold) begin
        memData[wrPtr] <= holdData;
        memStat[wrPtr] <= holdStat;
      end else if (strobe.pushIn) begin
        memData[wrPtr] <= charData;
        memStat[wrPtr] <= inStat;
      end
      if (strobe.clrHead) memStat[0] <= '0;
      if (strobe.loadHold) begin
        holdData <= charData;
        holdStat <= inStat;
      end
      if (strobe.accClr)       accum <= '0;
      else if (strobe.popHead) accum <= accum | memStat[rdPtr];
    end
  end

  assign headStat  = memStat[rdPtr];
  assign rdData    = memData[rdPtr];
  assign shownStat = blockErrMode ? (accum | (notEmpty ? headStat : '0)) : headStat;
endmodule

// File: rtl/rx_hold_buffer.sv
module rx_hold_buffer
  import rxhb_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rxEnable,
  input  logic              wakeMode,
  input  logic              blockErrMode,
  input  logic              autoFlow,
  input  logic              startBit,
  input  logic              charDone,
  input  logic [DATA_W-1:0] charData,
  input  logic              charParity,
  input  logic              charFrame,
  input  logic              charBreak,
  input  logic              dataRd,
  input  logic              errReset,
  input  logic              rxReset,
  output logic [DATA_W-1:0] rdData,
  output logic              ready,
  output logic              full,
  output logic              parityErr,
  output logic              frameErr,
  output logic              breakSeen,
  output logic              overrun,
  output logic              sendReq
);
  localparam int PTR_W = $clog2(DEPTH);

  strobe_t          strobe;
  logic [PTR_W-1:0] wrPtr, rdPtr;
  stat_t            shownStat;

  rxhb_ctrl #(.DEPTH(DEPTH), .PTR_W(PTR_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .rxEnable(rxEnable), .wakeMode(wakeMode),
    .autoFlow(autoFlow), .startBit(startBit), .charDone(charDone),
    .charParity(charParity), .dataRd(dataRd), .errReset(errReset),
    .rxReset(rxReset), .strobe(strobe), .wrPtr(wrPtr), .rdPtr(rdPtr),
    .ready(ready), .full(full), .overrun(overrun), .sendReq(sendReq)
  );

  rxhb_data #(.DATA_W(DATA_W), .DEPTH(DEPTH), .PTR_W(PTR_W)) data_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wrPtr(wrPtr), .rdPtr(rdPtr),
    .notEmpty(ready), .blockErrMode(blockErrMode), .charData(charData),
    .charParity(charParity), .charFrame(charFrame), .charBreak(charBreak),
    .rdData(rdData), .shownStat(shownStat)
  );

  assign parityErr = shownStat[PAR_B];
  assign frameErr  = shownStat[FRM_B];
  assign breakSeen = shownStat[BRK_B];
endmodule

// File: rtl/rx_hold_buffer_chk.sv
module rx_hold_buffer_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              rxEnable,
  input logic              wakeMode,
  input logic              charParity,
  input logic              charDone,
  input logic              dataRd,
  input logic              errReset,
  input logic              rxReset,
  input logic [DATA_W-1:0] rdData,
  input logic              ready,
  input logic              full,
  input logic              overrun,
  input logic              sendReq
);
  // R1: a full buffer is never reported as empty
  p_full_ready_r1: assert property (@(posedge clk) disable iff (!rstN)
    full |-> ready);

  // R1: without read, write or receiver reset the head and flags hold
  p_quiet_stable_r1: assert property (@(posedge clk) disable iff (!rstN)
    (!dataRd && !charDone && !rxReset) |=> ($stable(rdData) && $stable(ready) && $stable(full)));

  // R5: overrun is sticky until the reset-error command
  p_overrun_sticky_r5: assert property (@(posedge clk) disable iff (!rstN)
    (overrun && !errReset) |=> overrun);

  // R6: a pop always re-grants the remote sender
  p_pop_regrant_r6: assert property (@(posedge clk) disable iff (!rstN)
    (dataRd && ready && !rxReset) |=> sendReq);

  // R7: receiver reset empties the buffer
  p_rx_reset_empty_r7: assert property (@(posedge clk) disable iff (!rstN)
    rxReset |=> (!ready && !full));

  // R9: an unmarked character while asleep does not change the flags
  p_wake_filter_r9: assert property (@(posedge clk) disable iff (!rstN)
    (wakeMode && !rxEnable && charDone && !charParity && !dataRd && !rxReset)
      |=> ($stable(ready) && $stable(full)));
endmodule

bind rx_hold_buffer rx_hold_buffer_chk #(.DATA_W(DATA_W)) chk_i (
  .clk(clk), .rstN(rstN), .rxEnable(rxEnable), .wakeMode(wakeMode),
  .charParity(charParity), .charDone(charDone), .dataRd(dataRd),
  .errReset(errReset), .rxReset(rxReset), .rdData(rdData), .ready(ready),
  .full(full), .overrun(overrun), .sendReq(sendReq)
);

// File: tb/rx_hold_buffer_tb_top.sv
`timescale 1ns/1ps
module rx_hold_buffer_tb_top;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       rxEnable = 1'b0, wakeMode = 1'b0, blockErrMode = 1'b0, autoFlow = 1'b0;
  logic       startBit = 1'b0, charDone = 1'b0, dataRd = 1'b0, errReset = 1'b0, rxReset = 1'b0;
  logic [7:0] charData = '0;
  logic       charParity = 1'b0, charFrame = 1'b0, charBreak = 1'b0;
  logic [7:0] rdData;
  logic       ready, full, parityErr, frameErr, breakSeen, overrun, sendReq;

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  string curTag = "R1";

  always #2.5 clk = ~clk;

  rx_hold_buffer dut_i (
    .clk(clk), .rstN(rstN), .rxEnable(rxEnable), .wakeMode(wakeMode),
    .blockErrMode(blockErrMode), .autoFlow(autoFlow), .startBit(startBit),
    .charDone(charDone), .charData(charData), .charParity(charParity),
    .charFrame(charFrame), .charBreak(charBreak), .dataRd(dataRd),
    .errReset(errReset), .rxReset(rxReset), .rdData(rdData), .ready(ready),
    .full(full), .parityErr(parityErr), .frameErr(frameErr),
    .breakSeen(breakSeen), .overrun(overrun), .sendReq(sendReq)
  );

  // behavioural reference state
  int mData [3];
  int mStat [3];   // bit2 parity, bit1 frame, bit0 break
  int rp, wp, cnt, hData, hStat, acc;
  bit hv, ov, rts;

  task automatic check(input string tag, input int act, input int exp, input string what);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s act=%0h exp=%0h", tag, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  always @(posedge clk) begin
    int inStat, expStat;
    bit pop, drain, accp, inPush, inHold, ovSet;
    int capLeft, oldCnt;
    inStat = (int'(charParity) << 2) | (int'(charFrame) << 1) | int'(charBreak);
    if (!rstN) begin
      for (int i = 0; i < 3; i++) begin mData[i] = 0; mStat[i] = 0; end
      rp = 0; wp = 0; cnt = 0; hv = 0; hData = 0; hStat = 0; acc = 0; ov = 0; rts = 0;
    end else begin
      if (rxReset) begin
        cnt = 0; rp = 0; wp = 0; hv = 0; mStat[0] = 0; rts = 0;
        if (errReset) ov = 0;
      end else begin
        oldCnt  = cnt;
        pop     = dataRd && cnt > 0;
        capLeft = cnt - int'(pop);
        drain   = hv && capLeft < 3;
        accp    = charDone && (rxEnable || (wakeMode && charParity));
        inPush  = accp && !hv && capLeft < 3;
        inHold  = accp && !inPush;
        ovSet   = hv && !drain && (startBit || accp);
        if (pop) begin acc = acc | mStat[rp]; rp = (rp + 1) % 3; end
        if (drain) begin mData[wp] = hData; mStat[wp] = hStat; wp = (wp + 1) % 3; hv = 0; end
        if (inPush) begin mData[wp] = int'(charData); mStat[wp] = inStat; wp = (wp + 1) % 3; end
        if (inHold) begin hData = int'(charData); hStat = inStat; hv = 1; end
        else if (startBit && hv) hv = 0;
        cnt = capLeft + int'(drain || inPush);
        if (!autoFlow || pop) rts = 0;
        else if (startBit && oldCnt == 3) rts = 1;
        if (ovSet) ov = 1; else if (errReset) ov = 0;
      end
      if (errReset) acc = 0;
    end
    #1;
    if (rstN) begin
      expStat = blockErrMode ? (acc | ((cnt > 0) ? mStat[rp] : 0)) : mStat[rp];
      check(curTag, int'(rdData), mData[rp], "rdData");
      check(curTag, int'(ready), int'(cnt > 0), "ready");
      check(curTag, int'(full), int'(cnt == 3), "full");
      check(blockErrMode ? "R3" : "R2",
            (int'(parityErr) << 2) | (int'(frameErr) << 1) | int'(breakSeen), expStat, "status");
      check("R5", int'(overrun), int'(ov), "overrun");
      check("R6", int'(sendReq), int'(!rts), "sendReq");
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      failures++;
      $display("FAIL watchdog expired act=%0d exp=<20000", cycles);
      summary();
      $finish;
    end
  end

  task automatic step(input bit sb, input bit cd, input bit rd, input bit er, input bit rr);
    @(negedge clk);
    startBit = sb; charDone = cd; dataRd = rd; errReset = er; rxReset = rr;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0);
  endtask

  task automatic setChar(input logic [7:0] d, input bit p, input bit f, input bit b);
    charData = d; charParity = p; charFrame = f; charBreak = b;
  endtask

  task automatic sendChar(input logic [7:0] d, input bit p, input bit f, input bit b);
    step(1, 0, 0, 0, 0);
    idle(1);
    setChar(d, p, f, b);
    step(0, 1, 0, 0, 0);
    idle(1);
  endtask

  task automatic readOne();
    step(0, 0, 1, 0, 0);
    idle(1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    idle(1);
    check("R1", int'(ready), 0, "ready after reset");
    check("R1", int'(sendReq), 1, "sendReq after reset");
    check("R1", int'(rdData), 0, "rdData after reset");

    // R1 / R2: fill in per-character view
    curTag = "R1";
    rxEnable = 1; autoFlow = 1;
    sendChar(8'h11, 0, 1, 0);
    check("R2", int'(frameErr), 1, "head framing");
    sendChar(8'h22, 1, 0, 0);
    sendChar(8'h33, 0, 0, 1);
    check("R1", int'(full), 1, "full after three");
    readOne();   // empty read is not needed; this one pops 0x11
    check("R2", int'(parityErr), 1, "head parity of 0x22");
    sendChar(8'h66, 0, 0, 0);   // refill slot 0

    // R4 / R6: character behind a full buffer
    curTag = "R4";
    step(1, 0, 0, 0, 0);
    idle(1);
    check("R6", int'(sendReq), 0, "negated on start while full");
    setChar(8'h44, 0, 1, 0);
    step(0, 1, 0, 0, 0);
    idle(1);
    readOne();                  // 0x44 drains into slot 1
    check("R4", int'(full), 1, "full kept after drain");
    check("R6", int'(sendReq), 1, "regrant after pop");

    // R5: overrun on start bit while held
    curTag = "R5";
    sendChar(8'h55, 0, 0, 0);   // held
    step(1, 0, 0, 0, 0);        // overrunning start bit
    idle(1);
    check("R5", int'(overrun), 1, "overrun set");
    check("R5", int'(rdData), 8'h33, "buffer untouched");
    idle(2);

    // R7: receiver reset keeps bytes, clears slot 0 status
    curTag = "R7";
    step(0, 0, 0, 0, 1);
    idle(1);
    check("R7", int'(ready), 0, "empty after rx reset");
    check("R7", int'(rdData), 8'h66, "slot 0 byte kept");
    check("R7", int'(frameErr), 0, "slot 0 status cleared");
    check("R5", int'(overrun), 1, "overrun survives rx reset");
    step(0, 0, 0, 1, 0);
    idle(1);
    check("R5", int'(overrun), 0, "overrun cleared");

    // R3 / R11: accumulated view and simultaneous read/write
    curTag = "R3";
    blockErrMode = 1;
    sendChar(8'hA1, 1, 0, 0);
    sendChar(8'hA2, 0, 0, 1);
    readOne();
    check("R3", int'(parityErr), 1, "accumulated parity");
    check("R3", int'(breakSeen), 1, "head break");
    curTag = "R11";
    step(1, 0, 0, 0, 0);
    setChar(8'hA3, 0, 1, 0);
    step(0, 1, 1, 0, 0);        // pop and push together
    idle(1);
    check("R11", int'(ready), 1, "count kept");
    check("R11", int'(rdData), 8'hA3, "new byte at head");
    step(0, 0, 0, 1, 0);        // clear accumulated part
    idle(1);
    check("R3", int'(parityErr), 0, "accumulated cleared");
    readOne();
    readOne();                  // empty read: ignored
    blockErrMode = 0;

    // R8: disabled, not wake-up
    curTag = "R8";
    step(0, 0, 0, 0, 1);
    rxEnable = 0;
    sendChar(8'h5A, 0, 0, 0);
    check("R8", int'(ready), 0, "discarded while disabled");

    // R9: wake-up, disabled
    curTag = "R9";
    wakeMode = 1;
    sendChar(8'h0D, 0, 0, 0);
    check("R9", int'(ready), 0, "data char filtered");
    sendChar(8'h7E, 1, 0, 0);
    check("R9", int'(ready), 1, "address char stored");
    check("R9", int'(parityErr), 1, "marker in parity slot");
    check("R9", int'(rdData), 8'h7E, "address byte");

    // R10: wake-up, enabled
    curTag = "R10";
    rxEnable = 1;
    sendChar(8'h3C, 0, 0, 0);
    readOne();
    check("R10", int'(rdData), 8'h3C, "data char stored when enabled");
    autoFlow = 0;
    idle(3);

    summary();
    $finish;
  end
endmodule